// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block sits beside the program/erase controller of a flash-style memory. It qualifies the hardware reset pin and times the recovery that follows it. It drives the open-drain ready/busy line through a pull-down enable, and it tells the rest of the device when new operations may start. When a reset catches a program, erase or erase-suspend operation, it sends a one-cycle abort to the program/erase engine. It then keeps the line pulled low through a longer recovery window than a reset taken in read or standby needs.

The block also gates incoming operation requests against the current controller mode. It derives the effective per-block protection mask: while the elevated-voltage unprotect flag sits on the reset pin, every block reads as unprotected, and the stored mask takes effect again the moment the flag is removed. All timing is counted in clock cycles. The reset pin and the flag reach the block already synchronised to `clk`.

Top module: `flash_rst_seq`

## Requirements
- R1: After the system reset `rst_n` is released, `dev_ready` is 1 and `pe_abort` is 0, and `rb_pulldown` follows the mode rule of R7.
- R2: A low phase on `hw_rst_n` that lasts fewer than T_PLPX consecutive sampled cycles is ignored: `dev_ready` stays 1 and `pe_abort` stays 0.
- R3: A reset is recognised on the T_PLPX-th consecutive clock edge that samples `hw_rst_n` low. `dev_ready` drops to 0 after that edge and stays 0 while the pin stays low.
- R4: If `pe_mode` is read (0) or standby (1) at the first low sample, `dev_ready` returns to 1 exactly T_PHEL cycles after the first edge that samples `hw_rst_n` high again, and `rb_pulldown` stays 0 throughout the recovery.
- R5: If `pe_mode` is program (2), erase (3) or erase-suspend (4) at the first low sample, the recovery lasts T_PLYH cycles instead. `rb_pulldown` is 1 from recognition to the end of recovery, whatever `pe_mode` does meanwhile, and it falls in the same cycle that `dev_ready` rises.
- R6: `pe_abort` is a single-cycle pulse in the cycle after recognition, issued only for a reset that caught one of the modes listed in R5.
- R7: Outside a recognised reset, `rb_pulldown` is 1 exactly when `pe_mode` is program (2) or erase (3), and 0 for read, standby and erase-suspend.
- R8: `req_ok` qualifies the request code `req_kind` (0 program, 1 erase, 2 erase-suspend, 3 reserved). Program and erase are granted only when `dev_ready` is 1 and `pe_mode` is neither program nor erase. Erase-suspend is granted only when `dev_ready` is 1 and `pe_mode` is erase. The reserved code is never granted.
- R9: `eff_prot[i]` equals `prot_mask[i]` when `unprot_hv` is 0, and is 0 for every block while `unprot_hv` is 1.
- R10: A low phase on `hw_rst_n` during recovery restarts the full recovery window when the pin rises again, even if that low phase is shorter than T_PLPX. The recovery keeps the length chosen at the first reset, and no second abort is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst_n | input | 1 | Synchronised hardware reset pin, active low |
| unprot_hv | input | 1 | Elevated-voltage temporary unprotect flag |
| pe_mode | input | 3 | Controller mode: 0 read, 1 standby, 2 program, 3 erase, 4 erase-suspend |
| req_kind | input | 2 | Presented request code: 0 program, 1 erase, 2 erase-suspend, 3 reserved |
| prot_mask | input | NBLK | Stored per-block protection bits |
| req_ok | output | 1 | The presented request may be accepted this cycle |
| dev_ready | output | 1 | Device ready for new operations |
| rb_pulldown | output | 1 | Pull-down enable for the open-drain ready/busy line |
| pe_abort | output | 1 | One-cycle abort request to the program/erase engine |
| eff_prot | output | NBLK | Effective per-block protection |

## Verification
The properties assume that `hw_rst_n` and `unprot_hv` are already synchronous to `clk`, and that `pe_mode` only carries the five defined codes. The stimulus changes every input on the falling edge, so each rising edge samples a settled value, and it drives only the defined mode codes. The bench steps through every request code against every mode. After an abort it returns the mode to read, as a real engine would, which exposes a pull-down that follows the live mode instead of the latched reset kind.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam logic [2:0] MD_READ  = 3'd0;
  localparam logic [2:0] MD_STBY  = 3'd1;
  localparam logic [2:0] MD_PROG  = 3'd2;
  localparam logic [2:0] MD_ERASE = 3'd3;
  localparam logic [2:0] MD_ESUSP = 3'd4;

  localparam logic [1:0] RQ_PROG  = 2'd0;
  localparam logic [1:0] RQ_ERASE = 2'd1;
  localparam logic [1:0] RQ_SUSP  = 2'd2;

  typedef enum logic [1:0] {ST_RUN, ST_LOW, ST_HELD, ST_REC} seq_st_t;

  // Modes in which the embedded controller actively drives the array.
  function automatic logic mode_busy(input logic [2:0] m);
    return (m == MD_PROG) || (m == MD_ERASE);
  endfunction

  // Modes whose interruption needs the long recovery window.
  function automatic logic mode_long(input logic [2:0] m);
    return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_ESUSP);
  endfunction
endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int T_PLPX = 8,
  parameter int T_PHEL = 5,
  parameter int T_PLYH = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_rst_n,
  input  logic [2:0] pe_mode,
  output logic       dev_ready,
  output logic       rb_pulldown,
  output logic       pe_abort
);
  localparam int TMAX0 = (T_PHEL > T_PLYH) ? T_PHEL : T_PLYH;
  localparam int TMAX  = (T_PLPX > TMAX0) ? T_PLPX : TMAX0;
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [CW-1:0] PLPX_LAST = CW'(T_PLPX - 1);
  localparam logic [CW-1:0] PHEL_LAST = CW'(T_PHEL - 1);
  localparam logic [CW-1:0] PLYH_LAST = CW'(T_PLYH - 1);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          long_q, long_d;
  logic          abort_d;
  logic [CW-1:0] rec_last;

  assign rec_last = long_q ? PLYH_LAST : PHEL_LAST;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    long_d  = long_q;
    abort_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (!hw_rst_n) begin
          long_d = mode_long(pe_mode);
          if (T_PLPX == 1) begin
            st_d    = ST_HELD;
            pend_d  = 1'b1;
            abort_d = mode_long(pe_mode);
          end else begin
            st_d  = ST_LOW;
            cnt_d = CW'(1);
          end
        end
      end
      ST_LOW: begin
        if (hw_rst_n) begin
          st_d  = pend_q ? ST_REC : ST_RUN;
          cnt_d = '0;
        end else if (cnt_q == PLPX_LAST) begin
          st_d    = ST_HELD;
          pend_d  = 1'b1;
          abort_d = long_q && !pend_q;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_HELD: begin
        if (hw_rst_n) begin
          st_d  = ST_REC;
          cnt_d = '0;
        end
      end
      ST_REC: begin
        if (!hw_rst_n) begin
          st_d  = (T_PLPX == 1) ? ST_HELD : ST_LOW;
          cnt_d = CW'(1);
        end else if (cnt_q == rec_last) begin
          st_d   = ST_RUN;
          pend_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      long_q   <= 1'b0;
      pe_abort <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      long_q   <= long_d;
      pe_abort <= abort_d;
    end
  end

  assign dev_ready   = !pend_q;
  assign rb_pulldown = pend_q ? long_q : mode_busy(pe_mode);
endmodule

// File: rtl/frs_req_gate.sv
module frs_req_gate
  import frs_pkg::*;
(
  input  logic       dev_ready,
  input  logic [2:0] pe_mode,
  input  logic [1:0] req_kind,
  output logic       req_ok
);
  always_comb begin
    unique case (req_kind)
      RQ_PROG, RQ_ERASE: req_ok = dev_ready && !mode_busy(pe_mode);
      RQ_SUSP:           req_ok = dev_ready && (pe_mode == MD_ERASE);
      default:           req_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/frs_prot_mask.sv
module frs_prot_mask #(
  parameter int NBLK = 8
) (
  input  logic            unprot_hv,
  input  logic [NBLK-1:0] prot_mask,
  output logic [NBLK-1:0] eff_prot
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign eff_prot[b] = prot_mask[b] & ~unprot_hv;
  end
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int NBLK   = 8,
  parameter int T_PLPX = 8,
  parameter int T_PHEL = 5,
  parameter int T_PLYH = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_rst_n,
  input  logic            unprot_hv,
  input  logic [2:0]      pe_mode,
  input  logic [1:0]      req_kind,
  input  logic [NBLK-1:0] prot_mask,
  output logic            req_ok,
  output logic            dev_ready,
  output logic            rb_pulldown,
  output logic            pe_abort,
  output logic [NBLK-1:0] eff_prot
);
  frs_ctrl #(.T_PLPX(T_PLPX), .T_PHEL(T_PHEL), .T_PLYH(T_PLYH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .pe_mode(pe_mode),
    .dev_ready(dev_ready), .rb_pulldown(rb_pulldown), .pe_abort(pe_abort)
  );

  frs_req_gate u_gate (
    .dev_ready(dev_ready), .pe_mode(pe_mode), .req_kind(req_kind), .req_ok(req_ok)
  );

  frs_prot_mask #(.NBLK(NBLK)) u_prot (
    .unprot_hv(unprot_hv), .prot_mask(prot_mask), .eff_prot(eff_prot)
  );
endmodule

// File: rtl/frs_chk.sv
module frs_chk
  import frs_pkg::*;
#(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_rst_n,
  input logic            unprot_hv,
  input logic [2:0]      pe_mode,
  input logic [1:0]      req_kind,
  input logic [NBLK-1:0] prot_mask,
  input logic            req_ok,
  input logic            dev_ready,
  input logic            rb_pulldown,
  input logic            pe_abort,
  input logic [NBLK-1:0] eff_prot
);
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_hv |-> (eff_prot == '0)); // R9
  AST_MASK_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    !unprot_hv |-> (eff_prot == prot_mask)); // R9
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_abort |=> !pe_abort); // R6
  AST_ABORT_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_abort |-> (rb_pulldown && !dev_ready)); // R5
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && req_kind != RQ_SUSP) |-> (dev_ready && !mode_busy(pe_mode))); // R8
  AST_READY_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ready) |-> $past(hw_rst_n)); // R4
  AST_READY_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_ready) |-> !$past(hw_rst_n)); // R3
endmodule

bind flash_rst_seq frs_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .unprot_hv(unprot_hv),
  .pe_mode(pe_mode), .req_kind(req_kind), .prot_mask(prot_mask),
  .req_ok(req_ok), .dev_ready(dev_ready), .rb_pulldown(rb_pulldown),
  .pe_abort(pe_abort), .eff_prot(eff_prot)
);

// File: tb/sim_flash_rst_seq.sv
`timescale 1ns/1ps
module sim_flash_rst_seq;
  localparam int NBLK = 8, T_PLPX = 4, T_PHEL = 3, T_PLYH = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst_n = 1'b1, unprot_hv = 1'b0;
  logic [2:0] pe_mode = 3'd0;
  logic [1:0] req_kind = 2'd0;
  logic [NBLK-1:0] prot_mask = '0;
  logic req_ok, dev_ready, rb_pulldown, pe_abort;
  logic [NBLK-1:0] eff_prot;

  always #5 clk = ~clk;

  flash_rst_seq #(.NBLK(NBLK), .T_PLPX(T_PLPX), .T_PHEL(T_PHEL), .T_PLYH(T_PLYH)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .unprot_hv(unprot_hv),
    .pe_mode(pe_mode), .req_kind(req_kind), .prot_mask(prot_mask),
    .req_ok(req_ok), .dev_ready(dev_ready), .rb_pulldown(rb_pulldown),
    .pe_abort(pe_abort), .eff_prot(eff_prot)
  );

  int vectors = 0, miscomp = 0;
  bit done = 0, comparing = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_busy(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3;
  endfunction
  function automatic bit m_long(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd4;
  endfunction

  // Behavioural reference: run lengths and a recovery countdown.
  int  low_run, rec_left;
  bit  held, pend, lng, restart, exp_abort;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run = 0; rec_left = 0; held = 0; pend = 0; lng = 0; restart = 0; exp_abort = 0;
    end else begin
      exp_abort = 0;
      if (!hw_rst_n) begin
        low_run++;
        if (low_run == 1 && !pend) lng = m_long(pe_mode);
        if (pend && !held) begin restart = 1; rec_left = 0; end
        if (low_run == T_PLPX && !held) begin
          held = 1;
          if (!pend) exp_abort = lng;
          pend = 1;
        end
      end else begin
        low_run = 0;
        if (held || restart) begin
          held = 0; restart = 0;
          rec_left = lng ? T_PLYH : T_PHEL;
        end else if (rec_left > 0) begin
          rec_left--;
          if (rec_left == 0) pend = 0;
        end
      end
    end
  end

  function automatic bit exp_ok();
    if (pend) return 0;
    case (req_kind)
      2'd0, 2'd1: return !m_busy(pe_mode);
      2'd2:       return pe_mode == 3'd3;
      default:    return 0;
    endcase
  endfunction

  int low_cnt, pd_cnt, ab_cnt;
  always @(negedge clk) if (comparing) begin
    #2;
    chk("R3/R4/R5 dev_ready", dev_ready, !pend);
    chk("R5/R7 rb_pulldown", rb_pulldown, pend ? lng : m_busy(pe_mode));
    chk("R6 pe_abort", pe_abort, exp_abort);
    chk("R8 req_ok", req_ok, exp_ok());
    chk("R9 eff_prot", eff_prot, unprot_hv ? 0 : prot_mask);
    if (!dev_ready) low_cnt++;
    if (rb_pulldown) pd_cnt++;
    if (pe_abort) ab_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a low phase of lo cycles with mode m at its first sample, engine
  // then drops to read; hold high for hi cycles.
  task automatic hw_pulse(input logic [2:0] m, input int lo, input int hi);
    @(negedge clk);
    pe_mode = m; hw_rst_n = 1'b0;
    #3; low_cnt = 0; pd_cnt = 0; ab_cnt = 0;
    @(negedge clk);
    pe_mode = 3'd0;
    tick(lo - 1);
    hw_rst_n = 1'b1;
    tick(hi);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    comparing = 1;
    tick(1);
    #2;
    // R1 reset state
    chk("R1 dev_ready after reset", dev_ready, 1);
    chk("R1 pe_abort after reset", pe_abort, 0);
    chk("R1 rb_pulldown after reset", rb_pulldown, 0);

    // R7 and R8: every mode against every request code
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        pe_mode = m[2:0]; req_kind = k[1:0];
      end
    end
    @(negedge clk); pe_mode = 3'd2; #2;
    chk("R7 pulldown in program", rb_pulldown, 1);
    @(negedge clk); pe_mode = 3'd4; req_kind = 2'd0; #2;
    chk("R7 pulldown in erase-suspend", rb_pulldown, 0);
    chk("R8 program granted in erase-suspend", req_ok, 1);
    @(negedge clk); pe_mode = 3'd3; req_kind = 2'd2; #2;
    chk("R8 suspend granted in erase", req_ok, 1);
    @(negedge clk); req_kind = 2'd1; #2;
    chk("R8 erase rejected while erasing", req_ok, 0);
    @(negedge clk); pe_mode = 3'd0; req_kind = 2'd0;

    // R9 masks with and without the unprotect flag
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      prot_mask = NBLK'(8'hA5 ^ (p * 37));
      unprot_hv = p[0];
    end
    @(negedge clk); prot_mask = '1; unprot_hv = 1'b1; #2;
    chk("R9 all blocks open under flag", eff_prot, 0);
    @(negedge clk); unprot_hv = 1'b0; #2;
    chk("R9 mask restored after flag", eff_prot, 8'hFF);

    // R2 pulses one cycle short of the minimum width
    hw_pulse(3'd0, T_PLPX - 1, 4);
    chk("R2 short pulse in read: ready low cycles", low_cnt, 0);
    hw_pulse(3'd2, T_PLPX - 1, 4);
    chk("R2 short pulse in program: aborts", ab_cnt, 0);
    chk("R2 short pulse in program: ready low cycles", low_cnt, 0);

    // R3 / R4 standby reset, exact minimum width and a longer one
    hw_pulse(3'd1, T_PLPX, 8);
    chk("R3 minimum-width pulse: ready low cycles", low_cnt, 1 + T_PHEL);
    hw_pulse(3'd1, 6, 8);
    chk("R4 standby reset: ready low cycles", low_cnt, 6 - T_PLPX + 1 + T_PHEL);
    chk("R4 standby reset: pulldown cycles", pd_cnt, 0);
    chk("R6 standby reset: aborts", ab_cnt, 0);

    // R5 / R6 program, erase-suspend and erase resets
    hw_pulse(3'd2, 5, 14);
    chk("R5 program reset: ready low cycles", low_cnt, 2 + T_PLYH);
    chk("R5 program reset: pulldown cycles", pd_cnt, 2 + T_PLYH);
    chk("R6 program reset: aborts", ab_cnt, 1);
    hw_pulse(3'd4, T_PLPX, 14);
    chk("R5 erase-suspend reset: ready low cycles", low_cnt, 1 + T_PLYH);
    chk("R6 erase-suspend reset: aborts", ab_cnt, 1);

    // R10 short low phase during recovery restarts the window
    hw_pulse(3'd3, 5, 2);
    hw_rst_n = 1'b0; tick(2);
    hw_rst_n = 1'b1; tick(3);
    #2;
    chk("R10 pulldown mid-recovery", rb_pulldown, 1);
    tick(12);
    chk("R10 restarted recovery: ready low cycles", low_cnt, 2 + 2 + 2 + T_PLYH);
    chk("R10 restarted recovery: aborts", ab_cnt, 1);

    tick(2);
    comparing = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule